// File: doc/BRIEF.md
# Cascadable Dual 8-bit Interval Timer

Two independent up-counting timers, each with its own compare byte, mode byte and interrupt control byte, advance by one on every cycle in which the count-clock enable `cnt_en` is high and the timer's run bit is set. A timer that holds its compare value at a count clock returns to zero on that count clock and raises its request flag, so one interval lasts compare+1 count clocks. The request flag stays set until software clears it. Each timer drives an interrupt output and a 2-bit priority level for an external interrupt controller.

Setting the cascade bit fuses the two timers into one 16-bit interval timer. The lower timer supplies the low byte and the upper timer counts the lower timer's carries. The 16-bit compare value is written in one wide bus access so that both halves change in the same cycle. In cascade only the upper timer raises a request. The recommended start order is level first, then clearing of stale flags, then the interrupt enable, then the upper run bit, then the lower run bit.

Top module: `dual_tmr8`

## Requirements
- R1: After reset, both counters, both compare bytes, both mode bytes and both interrupt control bytes read 0, and `irq0` and `irq1` are low.
- R2: With cascade off, a running timer adds 1 at each count clock. At a count clock where its count equals its compare byte, it goes to 0 and sets its request flag (bit 0 of its interrupt control byte) instead. After n count clocks from 0 with compare k, the count is n mod (k+1) and the flag is set when n > k.
- R3: Cascade is bit 0 of the upper mode byte (address 5). Run is bit 3 of each mode byte (addresses 4 and 5). In cascade, {upper, lower} counts up from 0x0000 as one 16-bit value. The upper count advances only on a count clock where the lower count wraps from 0xFF to 0x00 while both run bits are set.
- R4: In cascade with both run bits set, at a count clock where {upper, lower} equals {upper compare, lower compare}, both counters go to 0 and the upper request flag is set.
- R5: Register addresses are 0 lower count (read only), 1 upper count (read only), 2 lower compare, 3 upper compare, 4 lower mode, 5 upper mode, 6 lower interrupt control and 7 upper interrupt control. A wide access (`bus_wide`=1) covers the even/odd byte pair, with the even byte on data bits 7:0 and the odd byte on bits 15:8. Both bytes are written in the same cycle. A byte access uses bits 7:0 only and reads back with bits 15:8 at zero.
- R6: In cascade the lower timer's request flag is never set by hardware, so `irq0` stays low even with its enable set.
- R7: Each interrupt output equals its request flag ANDed with the enable in bit 1 of its interrupt control byte. Each level output equals bits 7:6 of that byte.
- R8: A request flag stays set until software writes 0 to bit 0 of its control byte. Writing 1 there has no effect. If hardware sets the flag in the same cycle as a clearing write, the flag ends set.
- R9: Clearing a run bit halts that counter and keeps its value. Setting the bit again resumes counting from that value.
- R10: In a cycle with `cnt_en` low, neither counter changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | Count clock enable, one count per high cycle |
| bus_wr | input | 1 | Write strobe |
| bus_wide | input | 1 | 1 = 16-bit access to an even/odd byte pair |
| bus_addr | input | 3 | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the address |
| irq0 | output | 1 | Lower timer interrupt request |
| irq0_lvl | output | 2 | Lower timer priority level |
| irq1 | output | 1 | Upper timer interrupt request |
| irq1_lvl | output | 2 | Upper timer priority level |

## Verification
The hardest situation to reach is a hardware flag set that falls in the same cycle as a software clear of that flag. The stimulus runs a timer into its compare value. It then drives the count pulse and the clearing write in the same clock cycle and reads back that the flag survived. The 16-bit wrap is also hard to reach. The stimulus runs 255 count clocks to reach 0x00FF, steps across the carry into the upper byte, and continues to the exact compare point. It also runs the lower timer alone past its wrap to show that the upper byte does not move.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
   localparam int unsigned ADDR_W        = 3;
   localparam logic [2:0]  A_CNT0        = 3'd0;
   localparam logic [2:0]  A_CNT1        = 3'd1;
   localparam logic [2:0]  A_CMP0        = 3'd2;
   localparam logic [2:0]  A_CMP1        = 3'd3;
   localparam logic [2:0]  A_MODE0       = 3'd4;
   localparam logic [2:0]  A_MODE1       = 3'd5;
   localparam logic [2:0]  A_ICTL0       = 3'd6;
   localparam logic [2:0]  A_ICTL1       = 3'd7;
   localparam int unsigned MODE_RUN_BIT  = 3;
   localparam int unsigned MODE_CASC_BIT = 0;
   localparam int unsigned ICTL_LVL_LO   = 6;
   localparam int unsigned ICTL_IE_BIT   = 1;
   localparam int unsigned ICTL_FLAG_BIT = 0;

   typedef struct packed {
      logic [1:0] lvl;
      logic       ie;
      logic       flag;
   } ictl_t;
endpackage

// File: rtl/dtmr_cnt.sv
module dtmr_cnt #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   input  logic         clr,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (clr)  q <= '0;
      else if (step) q <= q + 1'b1;
   end
endmodule

// File: rtl/dtmr_ctl.sv
module dtmr_ctl #(
   parameter int unsigned W = 8
) (
   input  logic         cnt_en,
   input  logic         run0,
   input  logic         run1,
   input  logic         casc,
   input  logic [W-1:0] q0,
   input  logic [W-1:0] q1,
   input  logic [W-1:0] k0,
   input  logic [W-1:0] k1,
   output logic [1:0]   step,
   output logic [1:0]   clr,
   output logic [1:0]   set_flag
);
   localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

   logic hit0, hit1, hit16, both, wrap0;

   always_comb begin
      hit0  = (q0 == k0);
      hit1  = (q1 == k1);
      hit16 = hit0 && hit1;
      both  = run0 && run1;
      wrap0 = (q0 == ALL_ONES);
      if (casc) begin
         clr[0]      = cnt_en && run0 && both && hit16;
         step[0]     = cnt_en && run0 && !(both && hit16);
         clr[1]      = cnt_en && both && hit16;
         step[1]     = cnt_en && both && wrap0 && !hit16;
         set_flag[0] = 1'b0;
         set_flag[1] = clr[1];
      end else begin
         clr[0]      = cnt_en && run0 && hit0;
         step[0]     = cnt_en && run0 && !hit0;
         clr[1]      = cnt_en && run1 && hit1;
         step[1]     = cnt_en && run1 && !hit1;
         set_flag[0] = clr[0];
         set_flag[1] = clr[1];
      end
   end
endmodule

// File: rtl/dtmr_regs.sv
module dtmr_regs
   import dtmr_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           bus_wr,
   input  logic           bus_wide,
   input  logic [2:0]     bus_addr,
   input  logic [2*W-1:0] bus_wdata,
   output logic [2*W-1:0] bus_rdata,
   input  logic [W-1:0]   q0,
   input  logic [W-1:0]   q1,
   input  logic [1:0]     set_flag,
   output logic [W-1:0]   k0,
   output logic [W-1:0]   k1,
   output logic           run0,
   output logic           run1,
   output logic           casc,
   output ictl_t          ictl0,
   output ictl_t          ictl1
);
   localparam int unsigned NREG = 1 << ADDR_W;

   logic [NREG-1:0] wen;
   logic [W-1:0]    wval [NREG];
   logic [W-1:0]    rview [NREG];
   logic [W-1:0]    cmp_q [2];
   logic [1:0]      run_q;
   ictl_t           ictl_q [2];
   logic            casc_q;

   generate
      for (genvar a = 0; a < NREG; a++) begin : g_lane
         localparam logic [2:0] AA = 3'(a);
         always_comb begin
            if (bus_wide) begin
               wen[a]  = bus_wr && (bus_addr[2:1] == AA[2:1]);
               wval[a] = AA[0] ? bus_wdata[2*W-1:W] : bus_wdata[W-1:0];
            end else begin
               wen[a]  = bus_wr && (bus_addr == AA);
               wval[a] = bus_wdata[W-1:0];
            end
         end
      end

      for (genvar i = 0; i < 2; i++) begin : g_tmr
         localparam int unsigned AC = 32'(A_CMP0)  + i;
         localparam int unsigned AM = 32'(A_MODE0) + i;
         localparam int unsigned AI = 32'(A_ICTL0) + i;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cmp_q[i]  <= '0;
               run_q[i]  <= 1'b0;
               ictl_q[i] <= '0;
            end else begin
               if (wen[AC]) cmp_q[i] <= wval[AC];
               if (wen[AM]) run_q[i] <= wval[AM][MODE_RUN_BIT];
               if (wen[AI]) begin
                  ictl_q[i].lvl <= wval[AI][ICTL_LVL_LO +: 2];
                  ictl_q[i].ie  <= wval[AI][ICTL_IE_BIT];
               end
               if (set_flag[i])
                  ictl_q[i].flag <= 1'b1;
               else if (wen[AI] && !wval[AI][ICTL_FLAG_BIT])
                  ictl_q[i].flag <= 1'b0;
            end
         end

         always_comb begin
            rview[AC] = cmp_q[i];
            rview[AM] = '0;
            rview[AM][MODE_RUN_BIT] = run_q[i];
            if (i == 1) rview[AM][MODE_CASC_BIT] = casc_q;
            rview[AI] = '0;
            rview[AI][ICTL_LVL_LO +: 2]  = ictl_q[i].lvl;
            rview[AI][ICTL_IE_BIT]   = ictl_q[i].ie;
            rview[AI][ICTL_FLAG_BIT] = ictl_q[i].flag;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             casc_q <= 1'b0;
      else if (wen[A_MODE1])  casc_q <= wval[A_MODE1][MODE_CASC_BIT];
   end

   assign rview[A_CNT0] = q0;
   assign rview[A_CNT1] = q1;

   always_comb begin
      if (bus_wide)
         bus_rdata = {rview[{bus_addr[2:1], 1'b1}], rview[{bus_addr[2:1], 1'b0}]};
      else
         bus_rdata = {{W{1'b0}}, rview[bus_addr]};
   end

   assign k0    = cmp_q[0];
   assign k1    = cmp_q[1];
   assign run0  = run_q[0];
   assign run1  = run_q[1];
   assign casc  = casc_q;
   assign ictl0 = ictl_q[0];
   assign ictl1 = ictl_q[1];
endmodule

// File: rtl/dual_tmr8.sv
module dual_tmr8
   import dtmr_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cnt_en,
   input  logic           bus_wr,
   input  logic           bus_wide,
   input  logic [2:0]     bus_addr,
   input  logic [2*W-1:0] bus_wdata,
   output logic [2*W-1:0] bus_rdata,
   output logic           irq0,
   output logic [1:0]     irq0_lvl,
   output logic           irq1,
   output logic [1:0]     irq1_lvl
);
   initial begin
      assert (W >= 8) else $error("dual_tmr8: W must be at least 8");
   end

   logic [W-1:0] q0, q1, k0, k1;
   logic [W-1:0] cnt_q [2];
   logic         run0, run1, casc, flag0, flag1, ie0, ie1;
   logic [1:0]   step, clr, set_flag;
   ictl_t        ictl0, ictl1;

   dtmr_regs #(.W(W)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wide(bus_wide),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .q0(q0), .q1(q1), .set_flag(set_flag), .k0(k0), .k1(k1),
      .run0(run0), .run1(run1), .casc(casc), .ictl0(ictl0), .ictl1(ictl1)
   );

   dtmr_ctl #(.W(W)) u_ctl (
      .cnt_en(cnt_en), .run0(run0), .run1(run1), .casc(casc),
      .q0(q0), .q1(q1), .k0(k0), .k1(k1),
      .step(step), .clr(clr), .set_flag(set_flag)
   );

   generate
      for (genvar i = 0; i < 2; i++) begin : g_cnt
         dtmr_cnt #(.W(W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .step(step[i]), .clr(clr[i]), .q(cnt_q[i])
         );
      end
   endgenerate

   assign q0       = cnt_q[0];
   assign q1       = cnt_q[1];
   assign flag0    = ictl0.flag;
   assign flag1    = ictl1.flag;
   assign ie0      = ictl0.ie;
   assign ie1      = ictl1.ie;
   assign irq0     = flag0 && ie0;
   assign irq1     = flag1 && ie1;
   assign irq0_lvl = ictl0.lvl;
   assign irq1_lvl = ictl1.lvl;
endmodule

// File: rtl/dtmr_checker.sv
module dtmr_checker #(
   parameter int unsigned W = 8
) (
   input logic           clk,
   input logic           rst_n,
   input logic           cnt_en,
   input logic           bus_wr,
   input logic           bus_wide,
   input logic [2:0]     bus_addr,
   input logic [2*W-1:0] bus_wdata,
   input logic [W-1:0]   q0,
   input logic [W-1:0]   q1,
   input logic [W-1:0]   k0,
   input logic [W-1:0]   k1,
   input logic           run0,
   input logic           run1,
   input logic           casc,
   input logic           flag0,
   input logic           flag1
);
   a_r2_step_up: assert property (@(posedge clk) disable iff (!rst_n)
      (!casc && run0 && cnt_en && q0 != k0) |=> (q0 == $past(q0) + 1'b1));

   a_r3_upper_waits_carry: assert property (@(posedge clk) disable iff (!rst_n)
      (casc && cnt_en && q0 != {W{1'b1}}) |=> (q1 == $past(q1) || q1 == '0));

   a_r4_wrap_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (casc && run0 && run1 && cnt_en && q0 == k0 && q1 == k1)
      |=> (q0 == '0 && q1 == '0 && flag1));

   a_r5_wide_cmp: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_wide && bus_addr[2:1] == 2'b01)
      |=> (k0 == $past(bus_wdata[W-1:0]) && k1 == $past(bus_wdata[2*W-1:W])));

   a_r6_no_lower_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (casc && !flag0) |=> !flag0);

   a_r9_halt_lower: assert property (@(posedge clk) disable iff (!rst_n)
      !run0 |=> $stable(q0));

   a_r9_halt_upper: assert property (@(posedge clk) disable iff (!rst_n)
      !run1 |=> $stable(q1));

   a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_en |=> ($stable(q0) && $stable(q1)));
endmodule

bind dual_tmr8 dtmr_checker #(.W(W)) u_dtmr_checker (
   .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .bus_wr(bus_wr),
   .bus_wide(bus_wide), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
   .q0(q0), .q1(q1), .k0(k0), .k1(k1), .run0(run0), .run1(run1),
   .casc(casc), .flag0(flag0), .flag1(flag1)
);

// File: tb/dual_tmr8_bench.sv
`timescale 1ns/1ps
module dual_tmr8_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cnt_en = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_wide = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        irq0, irq1;
   logic [1:0]  irq0_lvl, irq1_lvl;

   int n_chk = 0;
   int n_err = 0;

   always #2.5 clk = ~clk;

   dual_tmr8 u_dual_tmr8 (
      .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .bus_wr(bus_wr),
      .bus_wide(bus_wide), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq0(irq0), .irq0_lvl(irq0_lvl),
      .irq1(irq1), .irq1_lvl(irq1_lvl)
   );

   localparam int NV = 9;
   localparam logic [7:0] V_K [NV] = '{8'd5, 8'd5, 8'd5, 8'd5, 8'd0, 8'd0, 8'd255, 8'd255, 8'd3};
   localparam int         V_N [NV] = '{3, 5, 6, 7, 1, 4, 255, 256, 20};

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      cnt_en = 1'b0;
      bus_wr = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d, input logic wide);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_wide = wide;
      @(negedge clk);
      bus_wr = 1'b0; bus_wide = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, input logic wide, output logic [15:0] d);
      bus_addr = a; bus_wide = wide;
      #1;
      d = bus_rdata;
      bus_wide = 1'b0;
   endtask

   task automatic pulse(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         cnt_en = 1'b1;
      end
      @(negedge clk);
      cnt_en = 1'b0;
   endtask

   initial begin
      #900000;
      n_chk++; n_err++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      logic [15:0] d;
      do_reset();

      // R1 reset state
      for (int a = 0; a < 8; a++) begin
         rd(3'(a), 1'b0, d);
         check("R1 reg", int'(d), 0);
      end
      check("R1 irq", int'({irq0, irq1}), 0);

      // R2 table: 8-bit interval on the lower timer
      for (int v = 0; v < NV; v++) begin
         do_reset();
         wr(3'd2, {8'h00, V_K[v]}, 1'b0);
         wr(3'd4, 16'h0008, 1'b0);
         pulse(V_N[v]);
         rd(3'd0, 1'b0, d);
         check("R2 count", int'(d), V_N[v] % (int'(V_K[v]) + 1));
         rd(3'd6, 1'b0, d);
         check("R2 flag", int'(d[0]), (V_N[v] > int'(V_K[v])) ? 1 : 0);
      end

      // R2 on the upper timer alone, R7 gating and level
      do_reset();
      wr(3'd3, 16'h0002, 1'b0);
      wr(3'd7, 16'h0040, 1'b0);
      wr(3'd7, 16'h0042, 1'b0);
      wr(3'd5, 16'h0008, 1'b0);
      pulse(3);
      rd(3'd1, 1'b0, d);
      check("R2 upper count", int'(d), 0);
      check("R7 irq1", int'(irq1), 1);
      check("R7 irq1_lvl", int'(irq1_lvl), 1);
      wr(3'd7, 16'h0041, 1'b0);
      check("R7 irq1 gated", int'(irq1), 0);

      // R5 wide and byte access to compare
      do_reset();
      wr(3'd2, 16'hA5C3, 1'b1);
      rd(3'd2, 1'b1, d);
      check("R5 wide read", int'(d), 16'hA5C3);
      wr(3'd3, 16'hFF77, 1'b0);
      rd(3'd2, 1'b1, d);
      check("R5 byte write", int'(d), 16'h77C3);
      rd(3'd3, 1'b0, d);
      check("R5 byte read", int'(d), 16'h0077);

      // R3 R4 R6 cascade 16-bit
      do_reset();
      wr(3'd2, 16'h0102, 1'b1);
      wr(3'd6, 16'h0002, 1'b0);
      wr(3'd7, 16'h0080, 1'b0);
      wr(3'd7, 16'h0082, 1'b0);
      wr(3'd5, 16'h0009, 1'b0);
      wr(3'd4, 16'h0008, 1'b0);
      pulse(255);
      rd(3'd0, 1'b1, d);
      check("R3 before carry", int'(d), 16'h00FF);
      pulse(1);
      rd(3'd0, 1'b1, d);
      check("R3 carry", int'(d), 16'h0100);
      pulse(2);
      rd(3'd0, 1'b1, d);
      check("R4 at match", int'(d), 16'h0102);
      check("R4 no flag yet", int'(irq1), 0);
      pulse(1);
      rd(3'd0, 1'b1, d);
      check("R4 wrap", int'(d), 16'h0000);
      check("R4 irq1", int'(irq1), 1);
      check("R7 level", int'(irq1_lvl), 2);
      pulse(300);
      check("R6 irq0", int'(irq0), 0);
      rd(3'd6, 1'b0, d);
      check("R6 flag0", int'(d[0]), 0);

      // R8 flag write semantics
      wr(3'd7, 16'h0083, 1'b0);
      check("R8 write one keeps", int'(irq1), 1);
      wr(3'd7, 16'h0082, 1'b0);
      check("R8 write zero clears", int'(irq1), 0);
      wr(3'd7, 16'h0083, 1'b0);
      check("R8 write one no set", int'(irq1), 0);

      // R3 upper holds when only lower runs
      do_reset();
      wr(3'd5, 16'h0001, 1'b0);
      wr(3'd4, 16'h0008, 1'b0);
      pulse(300);
      rd(3'd0, 1'b1, d);
      check("R3 upper stopped", int'(d), 16'h002C);

      // R8 set wins over simultaneous clear
      do_reset();
      wr(3'd2, 16'h0002, 1'b0);
      wr(3'd4, 16'h0008, 1'b0);
      pulse(5);
      @(negedge clk);
      cnt_en = 1'b1; bus_wr = 1'b1; bus_addr = 3'd6; bus_wdata = 16'h0002; bus_wide = 1'b0;
      @(negedge clk);
      cnt_en = 1'b0; bus_wr = 1'b0;
      rd(3'd6, 1'b0, d);
      check("R8 set wins", int'(d[0]), 1);
      rd(3'd0, 1'b0, d);
      check("R8 count cleared", int'(d), 0);

      // R9 halt and resume, R10 idle
      do_reset();
      wr(3'd2, 16'h00FF, 1'b0);
      wr(3'd4, 16'h0008, 1'b0);
      pulse(10);
      wr(3'd4, 16'h0000, 1'b0);
      pulse(5);
      rd(3'd0, 1'b0, d);
      check("R9 halted", int'(d), 10);
      wr(3'd4, 16'h0008, 1'b0);
      pulse(3);
      rd(3'd0, 1'b0, d);
      check("R9 resumed", int'(d), 13);
      repeat (20) @(negedge clk);
      rd(3'd0, 1'b0, d);
      check("R10 idle", int'(d), 13);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule